// File: doc/BRIEF.md
# Descriptor Ring Chain Writer

This block takes one request, given as a count of source buffers and a count of destination buffers, and writes it into a circular memory of 64-bit descriptor slots as a complete chain. Source and destination buffers arrive on two separate valid/ready streams, each buffer as an address and a byte length. The block decides the order in which the buffers are consumed. After each source it takes destinations until their lengths cover that source. When the sources are exhausted it takes every remaining destination.

A header descriptor goes in front of every group of up to 31 buffer descriptors. Slots that already hold a next-pointer descriptor are stepped over, and each one stepped over inverts the running ring toggle. The chain ends with a null descriptor that carries the inverted toggle. The first header is written with the wrong toggle so that the consumer of the ring ignores it. Its toggle is corrected only after everything else is in memory, and the block then pulses done with the slot that holds the null descriptor. The memory read port returns only the type nibble of the slot the block is looking at. The block reads it combinationally.

Top module: `ring_chain_writer`

## Requirements
- R1: Every word has its type in bits 63:60. A buffer whose length has a nonzero value in its low 4 bits is written as type 2 (source) or 3 (destination), with the byte length in bits 59:44. Any other buffer is written as type 6 (mega source) or 7 (mega destination), with length/16 in bits 59:44. In both forms the address goes in bits 43:0.
- R2: A header word has type 1. Its other fields are: toggle at bit 58, end flag at bit 57, start flag at bit 56, count at bits 40:36, zero flags at bits 31:16 and the request ID at bits 15:0. The count is min(31, remaining), the end flag is set when 31 or fewer remain, and the start flag is set only on the first header.
- R3: A header is written before buffer positions 0, 31, 62 and so on, and only while buffers remain.
- R4: After each source, destinations are consumed until their summed lengths reach the source length. Destinations left over after the last source follow in order.
- R5: After each write the slot advances and wraps after slot RING_SLOTS-1. A slot whose type is 5 (next pointer) is skipped and inverts the running toggle. Headers after the first carry the running toggle.
- R6: The first header is first written with the inverted start toggle. The null word (type 0) carries the inverted running toggle at bit 58. The last write rewrites the first header with its toggle corrected. Done pulses in that cycle, and end_slot gives the slot of the null word.
- R7: A start whose slot is at or beyond RING_SLOTS, or whose two counts are both zero, raises err for one cycle and writes nothing.
- R8: After reset the block is idle, with no write, done or err. A start presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start a request (taken when idle) |
| start_reqid | input | 16 | Request ID placed in every header |
| start_nsrc | input | CNT_W | Number of source buffers |
| start_ndst | input | CNT_W | Number of destination buffers |
| start_slot | input | SW | First slot to write |
| start_toggle | input | 1 | Current valid toggle of the ring |
| busy | output | 1 | A request is in progress |
| src_valid | input | 1 | Source buffer available |
| src_addr | input | ADDR_W | Source buffer address |
| src_len | input | LEN_W | Source buffer byte length |
| src_ready | output | 1 | Source buffer taken when valid |
| dst_valid | input | 1 | Destination buffer available |
| dst_addr | input | ADDR_W | Destination buffer address |
| dst_len | input | LEN_W | Destination buffer byte length |
| dst_ready | output | 1 | Destination buffer taken when valid |
| rd_slot | output | SW | Slot whose type is being inspected |
| rd_kind | input | 4 | Type nibble held in slot rd_slot |
| wr_en | output | 1 | Memory write strobe |
| wr_slot | output | SW | Memory write slot |
| wr_word | output | 64 | Memory write data |
| done | output | 1 | Chain published (one cycle) |
| end_slot | output | SW | Slot holding the null word |
| err | output | 1 | Start rejected (one cycle) |

## Verification
The collision that matters is a header falling due on the same step as a next-pointer skip at the ring end. The 32nd buffer boundary then lands just past a next-pointer slot after the slot wrap, so the second header has to pick up a toggle that was inverted a moment earlier. The bench provokes this with a 40-buffer request that starts near the end of the ring, with next-pointer slots placed at the ring end and at the slot where the second header would otherwise go. It judges the result by comparing the whole ring image against an independently computed expectation and by counting the header writes. A second overlap, a new start pulse arriving while a chain is being written, is injected during an interleaved request, and the resulting image must equal the one for that request alone.

// File: rtl/ring_chain_pkg.sv
package ring_chain_pkg;

   typedef enum logic [2:0] {
      S_IDLE, S_HDR, S_BUF, S_SKIP, S_NULL, S_FLIP
   } wr_state_e;

   localparam logic [3:0] K_NULL = 4'h0;
   localparam logic [3:0] K_HDR  = 4'h1;
   localparam logic [3:0] K_SRC  = 4'h2;
   localparam logic [3:0] K_DST  = 4'h3;
   localparam logic [3:0] K_NPTR = 4'h5;
   localparam logic [3:0] K_MSRC = 4'h6;
   localparam logic [3:0] K_MDST = 4'h7;

   // header word: kind, pad, toggle, end, start, pad, count, pad, flags(0), id
   function automatic logic [63:0] make_hdr(input logic tog, input logic endp,
                                            input logic startp, input logic [4:0] cnt,
                                            input logic [15:0] rid);
      return {K_HDR, 1'b0, tog, endp, startp, 15'd0, cnt, 4'd0, 16'd0, rid};
   endfunction

   function automatic logic [63:0] make_null(input logic tog);
      return {K_NULL, 1'b0, tog, 58'd0};
   endfunction

endpackage

// File: rtl/rwr_slot_step.sv
module rwr_slot_step #(
   parameter int RING_SLOTS = 48,
   parameter int SW = 6
) (
   input  logic [SW-1:0] cur,
   output logic [SW-1:0] nxt
);
   localparam bit POW2 = ((RING_SLOTS & (RING_SLOTS - 1)) == 0);

   generate
      if (POW2) begin : g_pow2
         assign nxt = cur + SW'(1);
      end else begin : g_cmp
         assign nxt = (cur == SW'(RING_SLOTS - 1)) ? '0 : cur + SW'(1);
      end
   endgenerate
endmodule

// File: rtl/rwr_pick.sv
module rwr_pick #(
   parameter int CNT_W = 6,
   parameter int LEN_W = 20
) (
   input  logic [LEN_W-1:0] tgt,
   input  logic [CNT_W-1:0] src_left,
   input  logic [CNT_W-1:0] dst_left,
   input  logic [LEN_W-1:0] src_len,
   input  logic [LEN_W-1:0] dst_len,
   output logic             use_dst,
   output logic [LEN_W-1:0] tgt_nxt
);
   // destinations while the current source is not yet covered, or once sources are gone
   assign use_dst = (dst_left != '0) && ((tgt != '0) || (src_left == '0));

   always_comb begin
      if (use_dst)
         tgt_nxt = (dst_len < tgt) ? (tgt - dst_len) : '0;
      else
         tgt_nxt = src_len;
   end
endmodule

// File: rtl/rwr_buf_fmt.sv
module rwr_buf_fmt
   import ring_chain_pkg::*;
#(
   parameter int ADDR_W = 44,
   parameter int LEN_W = 20
) (
   input  logic              is_dst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic [63:0]       word
);
   logic [19:0] len20;
   logic        mega;
   logic [15:0] lenf;
   logic [3:0]  kind;

   generate
      if (LEN_W == 20) begin : g_full
         assign len20 = len;
      end else begin : g_ext
         assign len20 = 20'(len);
      end
   endgenerate

   assign mega = (len20[3:0] == 4'd0);
   assign lenf = mega ? len20[19:4] : len20[15:0];
   assign kind = is_dst ? (mega ? K_MDST : K_DST) : (mega ? K_MSRC : K_SRC);
   assign word = {kind, lenf, 44'(addr)};
endmodule

// File: rtl/ring_chain_writer.sv
module ring_chain_writer
   import ring_chain_pkg::*;
#(
   parameter int RING_SLOTS = 48,
   parameter int ADDR_W = 44,
   parameter int LEN_W = 20,
   parameter int CNT_W = 6,
   localparam int SW = $clog2(RING_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   input  logic [15:0]       start_reqid,
   input  logic [CNT_W-1:0]  start_nsrc,
   input  logic [CNT_W-1:0]  start_ndst,
   input  logic [SW-1:0]     start_slot,
   input  logic              start_toggle,
   output logic              busy,
   input  logic              src_valid,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [LEN_W-1:0]  src_len,
   output logic              src_ready,
   input  logic              dst_valid,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [LEN_W-1:0]  dst_len,
   output logic              dst_ready,
   output logic [SW-1:0]     rd_slot,
   input  logic [3:0]        rd_kind,
   output logic              wr_en,
   output logic [SW-1:0]     wr_slot,
   output logic [63:0]       wr_word,
   output logic              done,
   output logic [SW-1:0]     end_slot,
   output logic              err
);
   localparam int TOT_W = CNT_W + 1;
   localparam int GROUP = 31;

   initial begin
      assert (RING_SLOTS >= 4) else $fatal(1, "RING_SLOTS too small");
      assert (CNT_W >= 5) else $fatal(1, "CNT_W must be at least 5");
      assert (LEN_W <= 20 && LEN_W >= 16) else $fatal(1, "LEN_W out of range");
      assert (ADDR_W <= 44) else $fatal(1, "ADDR_W above 44");
   end

   wr_state_e        st;
   logic [SW-1:0]    cur_slot, nxt_slot, hdr0_slot;
   logic             tog, hdr_due, err_q;
   logic [15:0]      rid;
   logic [CNT_W-1:0] src_left, dst_left;
   logic [TOT_W-1:0] pos, total, rem, start_total;
   logic [4:0]       grp, hcnt;
   logic [LEN_W-1:0] tgt, tgt_nxt, sel_len;
   logic [ADDR_W-1:0] sel_addr;
   logic [63:0]      hdr0_word, hdr_word, buf_word;
   logic             use_dst, sel_valid, last_grp, first, bad_start;

   rwr_slot_step #(.RING_SLOTS(RING_SLOTS), .SW(SW)) u_step (
      .cur(cur_slot), .nxt(nxt_slot));

   rwr_pick #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_pick (
      .tgt(tgt), .src_left(src_left), .dst_left(dst_left),
      .src_len(src_len), .dst_len(dst_len),
      .use_dst(use_dst), .tgt_nxt(tgt_nxt));

   assign sel_addr  = use_dst ? dst_addr : src_addr;
   assign sel_len   = use_dst ? dst_len : src_len;
   assign sel_valid = use_dst ? dst_valid : src_valid;

   rwr_buf_fmt #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fmt (
      .is_dst(use_dst), .addr(sel_addr), .len(sel_len), .word(buf_word));

   // header fields for the group starting at pos
   assign rem      = total - pos;
   assign last_grp = (rem <= TOT_W'(GROUP));
   assign hcnt     = last_grp ? rem[4:0] : 5'(GROUP);
   assign first    = (pos == '0);
   assign hdr_word = make_hdr(first ? ~tog : tog, last_grp, first, hcnt, rid);

   assign start_total = {1'b0, start_nsrc} + {1'b0, start_ndst};
   assign bad_start   = ({1'b0, start_slot} >= (SW+1)'(RING_SLOTS)) ||
                        (start_total == '0);

   assign busy      = (st != S_IDLE);
   assign src_ready = (st == S_BUF) && !use_dst;
   assign dst_ready = (st == S_BUF) && use_dst;
   assign rd_slot   = cur_slot;
   assign done      = (st == S_FLIP);
   assign end_slot  = cur_slot;
   assign err       = err_q;

   always_comb begin
      wr_en   = 1'b0;
      wr_slot = cur_slot;
      wr_word = buf_word;
      case (st)
         S_HDR:  begin wr_en = 1'b1; wr_word = hdr_word; end
         S_BUF:  wr_en = sel_valid;
         S_NULL: begin wr_en = 1'b1; wr_word = make_null(~tog); end
         S_FLIP: begin wr_en = 1'b1; wr_slot = hdr0_slot; wr_word = hdr0_word; end
         default: wr_en = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         cur_slot  <= '0;
         hdr0_slot <= '0;
         hdr0_word <= '0;
         tog       <= 1'b0;
         hdr_due   <= 1'b0;
         err_q     <= 1'b0;
         rid       <= '0;
         src_left  <= '0;
         dst_left  <= '0;
         pos       <= '0;
         total     <= '0;
         grp       <= '0;
         tgt       <= '0;
      end else begin
         err_q <= 1'b0;
         case (st)
            S_IDLE: begin
               if (start_valid) begin
                  if (bad_start) begin
                     err_q <= 1'b1;
                  end else begin
                     cur_slot <= start_slot;
                     tog      <= start_toggle;
                     rid      <= start_reqid;
                     src_left <= start_nsrc;
                     dst_left <= start_ndst;
                     total    <= start_total;
                     pos      <= '0;
                     grp      <= '0;
                     tgt      <= '0;
                     hdr_due  <= 1'b1;
                     st       <= S_HDR;
                  end
               end
            end
            S_HDR: begin
               if (first) begin
                  hdr0_slot <= cur_slot;
                  hdr0_word <= make_hdr(tog, last_grp, 1'b1, hcnt, rid);
               end
               hdr_due  <= 1'b0;
               cur_slot <= nxt_slot;
               st       <= S_SKIP;
            end
            S_BUF: begin
               if (sel_valid) begin
                  if (use_dst) dst_left <= dst_left - CNT_W'(1);
                  else         src_left <= src_left - CNT_W'(1);
                  tgt <= tgt_nxt;
                  pos <= pos + TOT_W'(1);
                  if (grp == 5'(GROUP - 1)) begin
                     grp     <= '0;
                     hdr_due <= 1'b1;
                  end else begin
                     grp <= grp + 5'd1;
                  end
                  cur_slot <= nxt_slot;
                  st       <= S_SKIP;
               end
            end
            S_SKIP: begin
               if (rd_kind == K_NPTR) begin
                  tog      <= ~tog;
                  cur_slot <= nxt_slot;
               end else if (pos == total) begin
                  st <= S_NULL;
               end else if (hdr_due) begin
                  st <= S_HDR;
               end else begin
                  st <= S_BUF;
               end
            end
            S_NULL: st <= S_FLIP;
            S_FLIP: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rwr_checker.sv
module rwr_checker #(
   parameter int RING_SLOTS = 48,
   parameter int SW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          err,
   input logic          done,
   input logic          wr_en,
   input logic [SW-1:0] wr_slot,
   input logic [SW-1:0] end_slot,
   input logic [7:0]    w_top,
   input logic [4:0]    w_cnt,
   input logic [15:0]   w_flags,
   input logic          src_ready,
   input logic          src_valid,
   input logic          dst_ready
);
   assert_src_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ready && src_valid) |-> (wr_en && (w_top[7:4] == 4'h2 || w_top[7:4] == 4'h6)));

   assert_hdr_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && w_top[7:4] == 4'h1) |-> (w_cnt != 5'd0 && w_flags == 16'd0));

   assert_one_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({src_ready, dst_ready}));

   assert_slot_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ({1'b0, wr_slot} < (SW+1)'(RING_SLOTS)));

   assert_null_before_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(wr_en) && $past(w_top[7:4]) == 4'h0 && $past(wr_slot) == end_slot));

   assert_flip_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wr_en && w_top[7:4] == 4'h1 && w_top[0]));

   assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!wr_en && !busy));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!wr_en && !done));
endmodule

bind ring_chain_writer rwr_checker #(.RING_SLOTS(RING_SLOTS), .SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .done(done),
   .wr_en(wr_en), .wr_slot(wr_slot), .end_slot(end_slot),
   .w_top(wr_word[63:56]), .w_cnt(wr_word[40:36]), .w_flags(wr_word[31:16]),
   .src_ready(src_ready), .src_valid(src_valid), .dst_ready(dst_ready));

// File: tb/sim_ring_chain_writer.sv
module sim_ring_chain_writer;
   localparam int CLK_PERIOD = 10;
   localparam int RS = 48;
   localparam int SW = 6;
   localparam int CNT_W = 6;
   localparam int LEN_W = 20;
   localparam int AW = 44;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              start_valid = 1'b0;
   logic [15:0]       start_reqid = '0;
   logic [CNT_W-1:0]  start_nsrc = '0, start_ndst = '0;
   logic [SW-1:0]     start_slot = '0;
   logic              start_toggle = 1'b0;
   logic              busy, src_ready, dst_ready, src_valid, dst_valid;
   logic [AW-1:0]     src_addr, dst_addr;
   logic [LEN_W-1:0]  src_len, dst_len;
   logic [SW-1:0]     rd_slot, wr_slot, end_slot;
   logic [3:0]        rd_kind;
   logic              wr_en, done, err;
   logic [63:0]       wr_word;

   logic [63:0] mem [RS];
   logic [63:0] exp_mem [RS];
   logic [AW-1:0]    sa [32], da [32];
   logic [LEN_W-1:0] sl [32], dl [32];
   int ns = 0, nd = 0, si = 0, di = 0;
   logic clr = 1'b0;
   int wcount = 0;
   logic [SW-1:0] wl_slot [128];
   logic [63:0]   wl_word [128];
   int checks = 0, errors = 0;

   ring_chain_writer u0 (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_reqid(start_reqid),
      .start_nsrc(start_nsrc), .start_ndst(start_ndst), .start_slot(start_slot),
      .start_toggle(start_toggle), .busy(busy),
      .src_valid(src_valid), .src_addr(src_addr), .src_len(src_len), .src_ready(src_ready),
      .dst_valid(dst_valid), .dst_addr(dst_addr), .dst_len(dst_len), .dst_ready(dst_ready),
      .rd_slot(rd_slot), .rd_kind(rd_kind), .wr_en(wr_en), .wr_slot(wr_slot),
      .wr_word(wr_word), .done(done), .end_slot(end_slot), .err(err));

   assign rd_kind   = mem[rd_slot][63:60];
   assign src_valid = (si < ns);
   assign dst_valid = (di < nd);
   assign src_addr  = (si < 32) ? sa[si] : '0;
   assign src_len   = (si < 32) ? sl[si] : '0;
   assign dst_addr  = (di < 32) ? da[di] : '0;
   assign dst_len   = (di < 32) ? dl[di] : '0;

   always @(posedge clk) begin
      if (clr) begin
         si <= 0; di <= 0; wcount <= 0;
      end else begin
         if (src_valid && src_ready) si <= si + 1;
         if (dst_valid && dst_ready) di <= di + 1;
         if (wr_en) begin
            mem[wr_slot] <= wr_word;
            if (wcount < 128) begin
               wl_slot[wcount] <= wr_slot;
               wl_word[wcount] <= wr_word;
            end
            wcount <= wcount + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // ---------------- reference model from the requirements ----------------
   int m_p, m_pos, m_tot;
   logic m_t;
   logic [15:0] m_rid;

   function automatic logic [63:0] fmt_buf(input bit is_dst, input logic [AW-1:0] a,
                                           input logic [LEN_W-1:0] l);
      bit mega = (l[3:0] == 4'd0);
      logic [3:0] k = is_dst ? (mega ? 4'h7 : 4'h3) : (mega ? 4'h6 : 4'h2);
      logic [15:0] f = mega ? l[19:4] : l[15:0];
      return {k, f, a};
   endfunction

   task automatic m_step();
      m_p = (m_p + 1) % RS;
      while (exp_mem[m_p][63:60] == 4'h5) begin
         m_t = ~m_t;
         m_p = (m_p + 1) % RS;
      end
   endtask

   task automatic m_emit(input logic [63:0] w);
      if (m_pos % 31 == 0) begin
         int rem = m_tot - m_pos;
         logic [4:0] c = (rem > 31) ? 5'd31 : 5'(rem);
         exp_mem[m_p] = {4'h1, 1'b0, (m_pos == 0) ? ~m_t : m_t, rem <= 31, m_pos == 0,
                         15'd0, c, 4'd0, 16'd0, m_rid};
         m_step();
      end
      exp_mem[m_p] = w;
      m_step();
      m_pos++;
   endtask

   task automatic model(input int slot, input logic tog, input logic [15:0] rid,
                        output int end_p);
      int s = 0, d = 0;
      longint tgt = 0;
      for (int i = 0; i < RS; i++) exp_mem[i] = mem[i];
      m_p = slot; m_t = tog; m_pos = 0; m_tot = ns + nd; m_rid = rid;
      while (s < ns || d < nd) begin
         if (s < ns) begin
            m_emit(fmt_buf(1'b0, sa[s], sl[s]));
            tgt = sl[s];
            s++;
         end else tgt = 64'hFFFF_FFFF;
         while (tgt != 0 && d < nd) begin
            m_emit(fmt_buf(1'b1, da[d], dl[d]));
            if (longint'(dl[d]) < tgt) tgt -= dl[d]; else tgt = 0;
            d++;
         end
      end
      exp_mem[m_p] = {4'h0, 1'b0, ~m_t, 58'd0};
      end_p = m_p;
      exp_mem[slot][58] = ~exp_mem[slot][58];
   endtask

   // ---------------- helpers ----------------
   task automatic clear_ring();
      for (int i = 0; i < RS; i++) mem[i] = 64'h0;
   endtask

   task automatic put_nptr(input int s);
      mem[s] = {4'h5, 16'h0, 44'(s * 64)};
   endtask

   task automatic run_req(input int slot, input logic tog, input logic [15:0] rid,
                          input bit inject, output bit got_done, output bit got_err,
                          output int eslot);
      got_done = 0; got_err = 0; eslot = -1;
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      start_valid = 1'b1; start_reqid = rid; start_slot = SW'(slot);
      start_toggle = tog; start_nsrc = CNT_W'(ns); start_ndst = CNT_W'(nd);
      @(negedge clk); start_valid = 1'b0;
      for (int k = 0; k < 600; k++) begin
         if (done) begin got_done = 1; eslot = int'(end_slot); break; end
         if (err) begin got_err = 1; break; end
         if (inject && k == 3) begin
            start_valid = 1'b1; start_reqid = 16'hDEAD; start_slot = 6'd1;
         end
         if (inject && k == 4) start_valid = 1'b0;
         @(negedge clk);
      end
      start_valid = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic check_mem(input string req);
      int bad = -1;
      for (int i = 0; i < RS; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
      if (bad < 0) check(1'b1, req, "ring image", 0, 0);
      else check(1'b0, req, $sformatf("ring slot %0d", bad), mem[bad], exp_mem[bad]);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(!busy && !wr_en && !done && !err, "R8", "idle after reset",
            {busy, wr_en, done, err}, 0);
   endtask

   task automatic t_basic();
      bit d, e; int es, xe;
      clear_ring();
      ns = 1; nd = 1;
      sa[0] = 44'h123_4567_89A; sl[0] = 20'h35;
      da[0] = 44'h0AB_CDEF_012; dl[0] = 20'h35;
      model(5, 1'b1, 16'h0042, xe);
      run_req(5, 1'b1, 16'h0042, 0, d, e, es);
      check(d, "R6", "basic done seen", d, 1);
      check(es == 8 && xe == 8, "R6", "basic end slot", es, 8);
      check_mem("R1 R2");
      check(mem[6][63:60] == 4'h2 && mem[6][59:44] == 16'h35, "R1", "byte-form source",
            mem[6][63:44], 20'h20035);
      check(wl_slot[0] == 6'd5 && wl_word[0][58] == 1'b0, "R6", "first header invalid toggle",
            wl_word[0][58], 0);
      check(wcount == 5 && wl_slot[4] == 6'd5 && wl_word[4][58] == 1'b1, "R6",
            "flip is last write", wcount, 5);
      check(wl_word[3][63:60] == 4'h0 && wl_word[3][58] == 1'b0 && wl_slot[3] == 6'd8, "R6",
            "null word with inverted toggle", wl_word[3][63:56], 0);
   endtask

   task automatic t_interleave();
      bit d, e; int es, xe;
      clear_ring();
      put_nptr(44);
      ns = 2; nd = 6;
      sa[0] = 44'h100; sl[0] = 20'h40;
      sa[1] = 44'h200; sl[1] = 20'h23;
      da[0] = 44'h300; dl[0] = 20'h10;
      da[1] = 44'h310; dl[1] = 20'h10;
      da[2] = 44'h320; dl[2] = 20'h20;
      da[3] = 44'h330; dl[3] = 20'h30;
      da[4] = 44'h340; dl[4] = 20'h5;
      da[5] = 44'h350; dl[5] = 20'h7;
      model(40, 1'b0, 16'h1234, xe);
      run_req(40, 1'b0, 16'h1234, 1, d, e, es);
      check(d && !e, "R8", "run completes despite start while busy", d, 1);
      check(es == xe, "R4", "interleave end slot", es, xe);
      check_mem("R4 R8");
      // order at slots 41,42,43,(44 skipped),45: S0 D0 D1 D2
      check(mem[41][63:60] == 4'h6 && mem[42][63:60] == 4'h7 && mem[45][63:60] == 4'h7 &&
            mem[46][63:60] == 4'h2, "R4", "source then covering destinations",
            {mem[41][63:60], mem[42][63:60], mem[45][63:60], mem[46][63:60]}, 16'h6772);
   endtask

   task automatic t_long();
      bit d, e; int es, xe, nh;
      clear_ring();
      put_nptr(47); put_nptr(15);
      ns = 20; nd = 20;
      for (int i = 0; i < 20; i++) begin
         sa[i] = 44'(32'h1000 + i * 16); sl[i] = 20'((i + 1) * 16);
         da[i] = 44'(32'h8000 + i * 16); dl[i] = 20'((i + 1) * 16);
      end
      model(30, 1'b1, 16'hBEEF, xe);
      run_req(30, 1'b1, 16'hBEEF, 0, d, e, es);
      check(d, "R3", "long request done", d, 1);
      check(es == xe, "R5", "end slot after wrap and skips", es, xe);
      check_mem("R3 R5");
      nh = 0;
      for (int i = 0; i < wcount && i < 128; i++) if (wl_word[i][63:60] == 4'h1) nh++;
      check(nh == 3, "R3", "two headers plus flip", nh, 3);
      check(mem[16][63:60] == 4'h1 && mem[16][40:36] == 5'd9 && mem[16][57:56] == 2'b10 &&
            mem[16][58] == 1'b1, "R5", "second header after skip keeps running toggle",
            mem[16][63:36], 0);
   endtask

   task automatic t_reject();
      bit d, e; int es;
      clear_ring();
      ns = 1; nd = 0; sa[0] = 44'h5; sl[0] = 20'h11;
      run_req(50, 1'b0, 16'h0001, 0, d, e, es);
      check(e && !d, "R7", "out-of-range slot rejected", e, 1);
      check(wcount == 0, "R7", "no write on reject", wcount, 0);
      ns = 0; nd = 0;
      run_req(3, 1'b0, 16'h0002, 0, d, e, es);
      check(e && !d, "R7", "empty request rejected", e, 1);
      check(wcount == 0 && mem[3] == 64'h0, "R7", "ring untouched", wcount, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_interleave();
      t_long();
      t_reject();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule